// File: doc/BRIEF.md
# Zero-Overhead Block Repeat Controller

This block is the loop engine of a DSP program sequencer. Once started, it repeats a run of program addresses without spending any cycle on the jump back. Each cycle it compares the fetch program counter with the stored block end address. When the fetch moves on from that address and more passes remain, it drives a next-PC override that points to the block start, in the same cycle. It also decrements the repeat counter. When the counter is already zero at a block end, the override is withheld: fetch falls through and the active flag drops.

The starting count comes from a software-written counter register and not from the start request. The value used is the one the register held two cycles before the start, so a write that lands too close to the start is not seen. Software can rewrite the counter during a loop. It can also end the loop early by writing zero to the active bit of the mode register. Blocks shorter than three words are refused. While an interrupt service routine runs, or on a fetch that is diverted to one, no block end is counted. The loop then resumes after the return.

FSM states: `RPT_IDLE` (no loop), `RPT_LOOP` (counter above zero, each block end wraps) and `RPT_LAST` (counter at zero, final pass). Transitions, in order of priority:
- Start: from any state to `RPT_LOOP` or `RPT_LAST`, depending on whether the loaded count is nonzero.
- Abort: from `RPT_LOOP` or `RPT_LAST` to `RPT_IDLE`.
- Counter rewrite: from `RPT_LOOP` or `RPT_LAST` to `RPT_LOOP` or `RPT_LAST`, depending on the written value.
- Wrap: `RPT_LOOP` to `RPT_LOOP` while the count is above one, otherwise `RPT_LOOP` to `RPT_LAST`.
- Finish: `RPT_LAST` to `RPT_IDLE`.

Top module: `blkrpt_ctrl`

## Requirements
- R1: A legal start sets the active flag. It loads the counter with the value the counter register held two cycles before the start cycle. A counter write made in the start cycle or the cycle before it does not change the loaded count.
- R2: When the PC equals the end address, `fetch_adv` is high and the controller is in `RPT_LOOP`, `pc_ovr_en` is high in that same cycle with `pc_ovr_addr` equal to the start address, and the counter decrements by one.
- R3: A loaded count of N gives exactly N+1 passes, so a count of 0 gives one pass. After the final pass the active flag is 0 and the counter reads 0.
- R4: The mode register reads back with the active flag in bit 0. When a loop ends, only bit 0 changes; bits 15..1 keep their values.
- R5: Writing the mode register with bit 0 = 0 during a loop withholds every later override. Fetch then leaves at the next block end. Writing bit 0 = 1 never sets the active flag.
- R6: A start whose end address is below the start address, or less than two above it, raises `len_err` for one cycle after the request and does not set the active flag.
- R7: The counter stays writable during a loop. The written value then sets the number of further wraps.
- R8: A block end fetched while `isr_active` is high neither wraps nor decrements. After the return, the loop completes its full pass count and clears the active flag.
- R9: The counter decrements once per pass, even when the PC stays on the end address for several cycles with `fetch_adv` high. No override is issued in those extra cycles.
- R10: After reset the flag is 0, the counter reads 0, the mode register reads 0, and `pc_ovr_en` and `len_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start a block repeat |
| start_addr | input | 16 | First address of the block |
| end_addr | input | 16 | Last address of the block |
| cnt_wr_en | input | 1 | Write the repeat counter |
| cnt_wr_data | input | 16 | Counter write value |
| st_wr_en | input | 1 | Write the mode register |
| st_wr_data | input | 16 | Mode write value, bit 0 is the active flag |
| pc | input | 16 | Current fetch address |
| fetch_adv | input | 1 | Fetch moves past the current address this cycle |
| isr_active | input | 1 | Fetch belongs to or is diverted to an interrupt routine |
| pc_ovr_en | output | 1 | Replace the next fetch address |
| pc_ovr_addr | output | 16 | Replacement fetch address (block start) |
| active | output | 1 | Loop active flag |
| count | output | 16 | Repeat counter value |
| mode | output | 16 | Mode register readback |
| len_err | output | 1 | Start refused for a too-short block |

## Verification
The hardest situations to reach from the ports are the ones where the PC sits on the end address and something other than a plain advance happens. One is an interrupt diverting that very fetch. Another is the PC holding there for extra strobed cycles. A third is an abort write or counter rewrite landing in a chosen pass. The bench runs a PC model that steps through addresses and follows the override, and that model can inject each of these events in a chosen pass. Every run is then judged by its total pass count, the final counter value and the final state of the flag.

// File: rtl/blkrpt_pkg.sv
package blkrpt_pkg;
    typedef enum logic [1:0] {
        RPT_IDLE = 2'd0,
        RPT_LOOP = 2'd1,
        RPT_LAST = 2'd2
    } rpt_state_e;
endpackage

// File: rtl/blkrpt_len_chk.sv
module blkrpt_len_chk #(
    parameter int AW      = 16,
    parameter int MIN_LEN = 3
) (
    input  logic [AW-1:0] blk_first,
    input  logic [AW-1:0] blk_last,
    output logic          len_ok
);
    localparam int        XW   = AW + 1;
    localparam logic [XW-1:0] SPAN = XW'(MIN_LEN - 1);

    logic [XW-1:0] diff;

    always_comb begin
        diff   = {1'b0, blk_last} - {1'b0, blk_first};
        len_ok = (blk_last >= blk_first) && (diff >= SPAN);
    end
endmodule

// File: rtl/blkrpt_cnt.sv
module blkrpt_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          load_en,
    input  logic          dec_en,
    output logic [CW-1:0] cnt_q,
    output logic          load_zero,
    output logic          cnt_one
);
    logic [CW-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hist_q <= '0;
        end else begin
            hist_q <= cnt_q;
            if (load_en)
                cnt_q <= hist_q;
            else if (wr_en)
                cnt_q <= wr_data;
            else if (dec_en)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        load_zero = (hist_q == '0);
        cnt_one   = (cnt_q == CW'(1));
    end

    AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/blkrpt_fsm.sv
module blkrpt_fsm
    import blkrpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_go,
    input  logic       load_zero,
    input  logic       boundary,
    input  logic       abort,
    input  logic       cnt_wr,
    input  logic       cnt_wr_zero,
    input  logic       cnt_one,
    output rpt_state_e state_q,
    output logic       ovr_en,
    output logic       dec_en
);
    rpt_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RPT_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ovr_en  = 1'b0;
        dec_en  = 1'b0;
        if (start_go) begin
            state_d = load_zero ? RPT_LAST : RPT_LOOP;
        end else begin
            unique case (state_q)
                RPT_IDLE: begin
                    state_d = RPT_IDLE;
                end
                RPT_LOOP: begin
                    if (abort) begin
                        state_d = RPT_IDLE;
                    end else begin
                        if (boundary) begin
                            ovr_en = 1'b1;
                            dec_en = !cnt_wr;
                        end
                        if (cnt_wr)
                            state_d = cnt_wr_zero ? RPT_LAST : RPT_LOOP;
                        else if (boundary)
                            state_d = cnt_one ? RPT_LAST : RPT_LOOP;
                    end
                end
                RPT_LAST: begin
                    if (abort)
                        state_d = RPT_IDLE;
                    else if (cnt_wr)
                        state_d = cnt_wr_zero ? RPT_LAST : RPT_LOOP;
                    else if (boundary)
                        state_d = RPT_IDLE;
                end
                default: state_d = RPT_IDLE;
            endcase
        end
    end

    AST_LAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RPT_LAST && boundary && !abort && !cnt_wr && !start_go)
        |=> (state_q == RPT_IDLE)); // R3
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !start_go) |=> (state_q == RPT_IDLE)); // R5
endmodule

// File: rtl/blkrpt_ctrl.sv
module blkrpt_ctrl
    import blkrpt_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 16,
    parameter int MODE_W  = 16,
    parameter int ACT_BIT = 0,
    parameter int MIN_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [AW-1:0]     start_addr,
    input  logic [AW-1:0]     end_addr,
    input  logic              cnt_wr_en,
    input  logic [CW-1:0]     cnt_wr_data,
    input  logic              st_wr_en,
    input  logic [MODE_W-1:0] st_wr_data,
    input  logic [AW-1:0]     pc,
    input  logic              fetch_adv,
    input  logic              isr_active,
    output logic              pc_ovr_en,
    output logic [AW-1:0]     pc_ovr_addr,
    output logic              active,
    output logic [CW-1:0]     count,
    output logic [MODE_W-1:0] mode,
    output logic              len_err
);
    localparam logic [MODE_W-1:0] ACT_MASK = MODE_W'(1) << ACT_BIT;

    rpt_state_e        state_q;
    logic              len_ok;
    logic              start_go;
    logic              load_zero;
    logic              cnt_one;
    logic              dec_en;
    logic              boundary;
    logic              abort;
    logic              guard_q;
    logic              at_end;
    logic [AW-1:0]     first_q;
    logic [AW-1:0]     last_q;
    logic [MODE_W-1:0] mode_q;

    blkrpt_len_chk #(.AW(AW), .MIN_LEN(MIN_LEN)) len_i (
        .blk_first (start_addr),
        .blk_last  (end_addr),
        .len_ok    (len_ok)
    );

    blkrpt_cnt #(.CW(CW)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cnt_wr_en),
        .wr_data   (cnt_wr_data),
        .load_en   (start_go),
        .dec_en    (dec_en),
        .cnt_q     (count),
        .load_zero (load_zero),
        .cnt_one   (cnt_one)
    );

    blkrpt_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_go    (start_go),
        .load_zero   (load_zero),
        .boundary    (boundary),
        .abort       (abort),
        .cnt_wr      (cnt_wr_en),
        .cnt_wr_zero (cnt_wr_data == '0),
        .cnt_one     (cnt_one),
        .state_q     (state_q),
        .ovr_en      (pc_ovr_en),
        .dec_en      (dec_en)
    );

    always_comb begin
        active      = (state_q != RPT_IDLE);
        start_go    = start_req && len_ok;
        at_end      = (pc == last_q);
        boundary    = active && fetch_adv && at_end && !isr_active && !guard_q;
        abort       = active && st_wr_en && !st_wr_data[ACT_BIT];
        pc_ovr_addr = first_q;
        mode        = (mode_q & ~ACT_MASK) | (active ? ACT_MASK : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            mode_q  <= '0;
            guard_q <= 1'b0;
            len_err <= 1'b0;
        end else begin
            len_err <= start_req && !len_ok;
            guard_q <= at_end && (guard_q || boundary);
            if (start_go) begin
                first_q <= start_addr;
                last_q  <= end_addr;
            end
            if (st_wr_en)
                mode_q <= st_wr_data & ~ACT_MASK;
        end
    end

    AST_OVR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ovr_en |-> (active && pc == last_q)); // R2
    AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !len_ok && !active) |=> (!active && len_err)); // R6
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !st_wr_en) |=> ((mode & ~ACT_MASK) == $past(mode & ~ACT_MASK))); // R4
    AST_ONE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> !dec_en); // R9
    AST_ISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        isr_active |-> (!dec_en && !pc_ovr_en)); // R8
endmodule

// File: tb/blkrpt_ctrl_tb.sv
module blkrpt_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] end_addr = '0;
    logic        cnt_wr_en = 1'b0;
    logic [15:0] cnt_wr_data = '0;
    logic        st_wr_en = 1'b0;
    logic [15:0] st_wr_data = '0;
    logic [15:0] pc_i = '0;
    logic        fetch_adv = 1'b0;
    logic        isr_active = 1'b0;
    logic        pc_ovr_en;
    logic [15:0] pc_ovr_addr;
    logic        active;
    logic [15:0] count;
    logic [15:0] mode;
    logic        len_err;

    int checks = 0;
    int errors = 0;
    int hold_bad = 0;

    localparam logic [15:0] MODE_PAT = 16'hA5A4;

    // vectors: {start, end, count, expected passes}
    localparam int NV = 5;
    localparam logic [63:0] VEC [NV] = '{
        {16'h0010, 16'h0012, 16'd0, 16'd1},
        {16'h0020, 16'h0022, 16'd1, 16'd2},
        {16'h0100, 16'h0108, 16'd5, 16'd6},
        {16'h0200, 16'h0203, 16'd3, 16'd4},
        {16'hFFF0, 16'hFFF5, 16'd2, 16'd3}
    };

    always #2 clk = ~clk;

    blkrpt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .start_addr(start_addr), .end_addr(end_addr),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
        .pc(pc_i), .fetch_adv(fetch_adv), .isr_active(isr_active),
        .pc_ovr_en(pc_ovr_en), .pc_ovr_addr(pc_ovr_addr),
        .active(active), .count(count), .mode(mode), .len_err(len_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_count(input logic [15:0] v);
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = v;
        @(negedge clk); cnt_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_loop(input logic [15:0] s, input logic [15:0] e,
                            input int abort_pass, input int irq_pass,
                            input int hold_pass, input int wr_pass,
                            input logic [15:0] wr_val, output int passes);
        logic [15:0] p;
        logic [15:0] tgt;
        logic        seen;
        bit          done;
        bit          irq_done;
        bit          wr_done;
        @(negedge clk); start_req = 1'b1; start_addr = s; end_addr = e;
        @(negedge clk); start_req = 1'b0;
        p = s; passes = 0; done = 0; irq_done = 0; wr_done = 0;
        for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
            if (cyc != 0) @(negedge clk);
            pc_i = p; fetch_adv = 1'b1; isr_active = 1'b0;
            st_wr_en = 1'b0; cnt_wr_en = 1'b0;
            if (p == e && passes == irq_pass && !irq_done) isr_active = 1'b1;
            if (p == e && !isr_active && passes + 1 == abort_pass) begin
                st_wr_en = 1'b1; st_wr_data = MODE_PAT;
            end
            if (p == s && passes == wr_pass && passes > 0 && !wr_done) begin
                cnt_wr_en = 1'b1; cnt_wr_data = wr_val; wr_done = 1;
            end
            #1;
            if (isr_active) begin
                irq_done = 1;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk); pc_i = 16'hFF00 + 16'(k);
                end
            end else if (p == e) begin
                passes++;
                seen = pc_ovr_en; tgt = pc_ovr_addr;
                if (passes == hold_pass) begin
                    for (int k = 0; k < 2; k++) begin
                        @(negedge clk); st_wr_en = 1'b0; cnt_wr_en = 1'b0; #1;
                        if (pc_ovr_en) hold_bad++;
                    end
                end
                if (seen) p = tgt;
                else begin p = e + 16'd1; done = 1; end
            end else begin
                p = p + 16'd1;
            end
        end
        @(negedge clk);
        fetch_adv = 1'b0; st_wr_en = 1'b0; cnt_wr_en = 1'b0; isr_active = 1'b0; pc_i = 16'h0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int np;
        repeat (3) @(negedge clk);
        #1;
        check("R10 active", active, 0);
        check("R10 count", count, 0);
        check("R10 mode", mode, 0);
        check("R10 ovr", pc_ovr_en, 0);
        check("R10 len_err", len_err, 0);
        rst_n = 1'b1;

        // R5: writing bit0=1 while idle does not set the flag; R4 pattern stored
        @(negedge clk); st_wr_en = 1'b1; st_wr_data = MODE_PAT | 16'h1;
        @(negedge clk); st_wr_en = 1'b0; #1;
        check("R5 set ignored", active, 0);
        check("R4 mode pattern", mode, MODE_PAT);

        // R1..R4 vector table
        for (int i = 0; i < NV; i++) begin
            set_count(VEC[i][31:16]);
            run_loop(VEC[i][63:48], VEC[i][47:32], -1, -1, -1, -1, 16'h0, np);
            check("R3 passes", np, VEC[i][15:0]);
            check("R3 flag clear", active, 0);
            check("R3 count zero", count, 0);
            check("R4 mode kept", mode, MODE_PAT);
        end

        // R2: override appears in the end-address cycle, pointing to start
        set_count(16'd1);
        @(negedge clk); start_req = 1'b1; start_addr = 16'h0300; end_addr = 16'h0304;
        @(negedge clk); start_req = 1'b0; pc_i = 16'h0304; fetch_adv = 1'b1; #1;
        check("R2 ovr en", pc_ovr_en, 1);
        check("R2 ovr addr", pc_ovr_addr, 16'h0300);
        @(negedge clk); pc_i = 16'h0300; #1;
        check("R2 count dec", count, 0);
        check("R2 no ovr off end", pc_ovr_en, 0);
        @(negedge clk); pc_i = 16'h0304; #1;
        check("R3 last pass no ovr", pc_ovr_en, 0);
        @(negedge clk); fetch_adv = 1'b0; pc_i = 16'h0; #1;
        check("R3 last pass clears", active, 0);

        // R6: short block and reversed block rejected
        @(negedge clk); start_req = 1'b1; start_addr = 16'h0400; end_addr = 16'h0401;
        @(negedge clk); start_req = 1'b0; #1;
        check("R6 len_err short", len_err, 1);
        check("R6 no start short", active, 0);
        @(negedge clk); #1;
        check("R6 len_err one cycle", len_err, 0);
        @(negedge clk); start_req = 1'b1; start_addr = 16'h0410; end_addr = 16'h0400;
        @(negedge clk); start_req = 1'b0; #1;
        check("R6 no start reversed", active, 0);

        // R1: late write ignored, write two cycles ahead used
        set_count(16'd2);
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = 16'd9;
        @(negedge clk); cnt_wr_en = 1'b0; start_req = 1'b1; start_addr = 16'h0500; end_addr = 16'h0505;
        @(negedge clk); start_req = 1'b0; #1;
        check("R1 active", active, 1);
        check("R1 late write ignored", count, 2);
        @(negedge clk); st_wr_en = 1'b1; st_wr_data = MODE_PAT;
        @(negedge clk); st_wr_en = 1'b0; #1;
        check("R5 abort idle", active, 0);
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = 16'd4;
        @(negedge clk); cnt_wr_en = 1'b0;
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0; #1;
        check("R1 early write used", count, 4);
        @(negedge clk); st_wr_en = 1'b1; st_wr_data = MODE_PAT;
        @(negedge clk); st_wr_en = 1'b0;

        // R5: abort during second pass
        set_count(16'd5);
        run_loop(16'h0600, 16'h0604, 2, -1, -1, -1, 16'h0, np);
        check("R5 abort passes", np, 2);
        check("R5 abort flag", active, 0);
        check("R5 abort count", count, 4);
        check("R4 mode after abort", mode, MODE_PAT);

        // R7: counter rewritten at start of pass 2
        set_count(16'd5);
        run_loop(16'h0700, 16'h0703, -1, -1, -1, 1, 16'd1, np);
        check("R7 rewritten passes", np, 3);
        check("R7 flag", active, 0);

        // R8: interrupt taken at end of pass 2
        set_count(16'd2);
        run_loop(16'h0800, 16'h0805, -1, 1, -1, -1, 16'h0, np);
        check("R8 irq passes", np, 3);
        check("R8 flag cleared", active, 0);
        check("R8 count", count, 0);

        // R9: PC held on end address with strobes
        hold_bad = 0;
        set_count(16'd2);
        run_loop(16'h0900, 16'h0903, -1, -1, 1, -1, 16'h0, np);
        check("R9 held passes", np, 3);
        check("R9 no extra ovr", hold_bad, 0);
        check("R9 count", count, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule